// File: doc/BRIEF.md
# Power-Fail Write Guard for an Asynchronous SRAM Port

This block sits between a host and a byte-wide asynchronous static memory. It passes the host's active-low chip-select, write and read strobes to the array while the supply is healthy. When a digitised supply monitor reports that the rail has dropped below the power-fail threshold, it cuts off the strobes and stops driving the data bus. An access that was already open when the failure was first seen may finish, but only within a bounded number of clock cycles. When the rail comes back, protection stays on for a long recovery interval before host traffic is allowed through again.

The block also chooses the backup energy source. The backup cell is left isolated until the first time the supply is seen valid. Once the block has been armed in this way, it switches to backup whenever the supply falls below the switchover level and returns to main supply when the rail rises above that level again. Only a dedicated clear input disarms the backup. A normal reset does not.

All five monitor and strobe inputs pass through a two-stage synchroniser. All outputs are registered. A change on an input therefore reaches the outputs on the third rising clock edge after it is applied.

Top module: `pwrfail_guard`

## Requirements
- R1: While `rst` is high and in the cycles just after it, `prot_active` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `bus_drive` is 0. `sel_backup` is 0 while `rst` is high.
- R2: With protection off, the strobe inputs decode to a bus mode. Chip-select high means standby: `mem_ce_n`=1 and `bus_drive`=0. Chip-select low with write and read both high means output off: `mem_ce_n`=0 and `bus_drive`=0. Chip-select low, write high and read low means a read: `bus_drive`=1 and `mem_oe_n`=0. Chip-select low with write low means a write, whatever the read input: `bus_drive`=0. The result appears on the third rising edge after the inputs change and not before.
- R3: `mem_we_n` is 0 only while both synchronised chip-select and write are low. It falls after the later of the two falling edges and rises after the earlier of the two rising edges.
- R4: If chip-select falls in the same cycle as write, or after write has already fallen, `bus_drive` stays 0 until chip-select goes high again, even if write later returns high with read low.
- R5: Suppose the power-fail flag `vdd_low` rises while chip-select is high. Then `prot_active` becomes 1 on the third edge. While protection holds, `mem_ce_n`=`mem_we_n`=1 and `bus_drive`=0, whatever the host strobes do.
- R6: Suppose `vdd_low` is first seen while chip-select is low. The host strobes keep reaching the array until chip-select or write is seen high. Protection then starts on the next edge.
- R7: An access in flight that does not finish is cut off. Protection starts exactly `WPT_CYC` edges after the edge where the failure was first acted on, which is the third edge after `vdd_low` rose.
- R8: After `vdd_low` falls, protection stays on, and host writes are blocked, for `REC_CYC` edges beyond the usual three-edge latency. `prot_active` drops on edge 3+`REC_CYC`.
- R9: Until the supply has been seen valid (`vdd_low`=0) at least once since the last arm clear, `bkup_armed` and `sel_backup` stay 0, even when `vdd_bkup_low`=1.
- R10: `bkup_armed` becomes 1 on the third edge after the supply is first valid. Once the block is armed, `sel_backup` follows `vdd_bkup_low` with three-edge latency.
- R11: `bkup_armed` is unaffected by `rst`. `arm_clear` clears it on the next edge and holds it at 0 while it stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the armed flag) |
| arm_clear | input | 1 | Synchronous clear of the backup-armed flag |
| host_ce_n | input | 1 | Host chip-select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host read strobe, active low |
| vdd_low | input | 1 | Supply below power-fail threshold |
| vdd_bkup_low | input | 1 | Supply below backup switchover level |
| mem_ce_n | output | 1 | Gated chip-select to the array |
| mem_we_n | output | 1 | Gated write strobe to the array |
| mem_oe_n | output | 1 | Gated read strobe to the array |
| bus_drive | output | 1 | Data bus output enable |
| sel_backup | output | 1 | Backup source selected (also on-backup status) |
| prot_active | output | 1 | Write protection in force |
| bkup_armed | output | 1 | Backup source armed |

## Verification
The assertions assume that the clear input is held high, together with reset, from time zero until the armed flag has a defined value. They also assume that the power-fail flag is never low while the switchover flag is high, because a rail below the switchover level is also below the fail threshold. The stimulus applies every input change on the falling clock edge. It raises the switchover flag only after the fail flag, and it keeps clear and reset asserted together at start-up. The bound on the drain window is checked with a counter of cycles since the fail flag rose, not with a long delay.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    PF_RUN     = 2'd0,
    PF_DRAIN   = 2'd1,
    PF_HOLD    = 2'd2,
    PF_RECOVER = 2'd3
  } pf_state_t;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pfg_prot_fsm.sv
module pfg_prot_fsm
  import pfg_pkg::*;
#(
  parameter int WPT_CYC = 20000,
  parameter int REC_CYC = 16000000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic ce_n,
  input  logic we_n,
  output logic gate_open_d
);
  localparam int MAXC  = (WPT_CYC > REC_CYC) ? WPT_CYC : REC_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WPT_LAST = CNT_W'(WPT_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  pf_state_t        state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = '0;
    case (state)
      PF_RUN: begin
        if (supply_low) nxt = ce_n ? PF_HOLD : PF_DRAIN;
      end
      PF_DRAIN: begin
        cnt_nxt = cnt + 1'b1;
        if (ce_n || we_n || cnt == WPT_LAST) nxt = PF_HOLD;
      end
      PF_HOLD: begin
        if (!supply_low) nxt = PF_RECOVER;
      end
      default: begin
        cnt_nxt = cnt + 1'b1;
        if (supply_low)            nxt = PF_HOLD;
        else if (cnt == REC_LAST)  nxt = PF_RUN;
      end
    endcase
  end

  assign gate_open_d = (nxt == PF_RUN) || (nxt == PF_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PF_HOLD;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt == state) ? cnt_nxt : '0;
    end
  end
endmodule

// File: rtl/pfg_decode.sv
module pfg_decode (
  input  logic clk,
  input  logic rst,
  input  logic gate_open_d,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic bus_drive,
  output logic prot_active
);
  logic ce_q, wr_first, wr_first_d, drive_d;

  always_comb begin
    if (ce_n)              wr_first_d = 1'b0;
    else if (ce_q)         wr_first_d = !we_n;
    else                   wr_first_d = wr_first;
    drive_d = gate_open_d && !ce_n && we_n && !oe_n && !wr_first_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q        <= 1'b1;
      wr_first    <= 1'b0;
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      bus_drive   <= 1'b0;
      prot_active <= 1'b1;
    end else begin
      ce_q        <= ce_n;
      wr_first    <= wr_first_d;
      mem_ce_n    <= !(gate_open_d && !ce_n);
      mem_we_n    <= !(gate_open_d && !ce_n && !we_n);
      mem_oe_n    <= !drive_d;
      bus_drive   <= drive_d;
      prot_active <= !gate_open_d;
    end
  end
endmodule

// File: rtl/pfg_backup.sv
module pfg_backup (
  input  logic clk,
  input  logic rst,
  input  logic arm_clear,
  input  logic supply_low,
  input  logic bkup_low,
  output logic sel_backup,
  output logic armed
);
  logic armed_d;

  always_comb begin
    if (arm_clear)        armed_d = 1'b0;
    else if (!supply_low) armed_d = 1'b1;
    else                  armed_d = armed;
  end

  always_ff @(posedge clk) armed <= armed_d;

  always_ff @(posedge clk) begin
    if (rst) sel_backup <= 1'b0;
    else     sel_backup <= armed_d && bkup_low;
  end
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
  parameter int WPT_CYC = 20000,
  parameter int REC_CYC = 16000000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_clear,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  input  logic vdd_low,
  input  logic vdd_bkup_low,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic bus_drive,
  output logic sel_backup,
  output logic prot_active,
  output logic bkup_armed
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw, syn;
  logic s_ce_n, s_we_n, s_oe_n, s_low, s_blow;
  logic gate_open_d;

  assign raw = {host_ce_n, host_we_n, host_oe_n, vdd_low, vdd_bkup_low};
  assign {s_ce_n, s_we_n, s_oe_n, s_low, s_blow} = syn;

  pfg_sync #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  pfg_prot_fsm #(.WPT_CYC(WPT_CYC), .REC_CYC(REC_CYC)) u_fsm (
    .clk(clk), .rst(rst), .supply_low(s_low),
    .ce_n(s_ce_n), .we_n(s_we_n), .gate_open_d(gate_open_d)
  );

  pfg_decode u_dec (
    .clk(clk), .rst(rst), .gate_open_d(gate_open_d),
    .ce_n(s_ce_n), .we_n(s_we_n), .oe_n(s_oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .bus_drive(bus_drive), .prot_active(prot_active)
  );

  pfg_backup u_bkp (
    .clk(clk), .rst(rst), .arm_clear(arm_clear),
    .supply_low(s_low), .bkup_low(s_blow),
    .sel_backup(sel_backup), .armed(bkup_armed)
  );
endmodule

// File: rtl/pwrfail_guard_chk.sv
module pwrfail_guard_chk #(
  parameter int WPT_CYC = 20000
) (
  input logic clk,
  input logic rst,
  input logic arm_clear,
  input logic vdd_low,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic bus_drive,
  input logic sel_backup,
  input logic prot_active,
  input logic bkup_armed
);
  int unsigned open_cnt;

  // cycles the fail flag has been high while the gate is still open
  always_ff @(posedge clk) begin
    if (rst || !vdd_low || prot_active) open_cnt <= 0;
    else if (open_cnt < WPT_CYC + 10)   open_cnt <= open_cnt + 1;
  end

  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (rst)
    prot_active |-> (mem_ce_n && mem_we_n && !bus_drive));

  assert_drive_is_read_R2: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (mem_we_n && !mem_ce_n && !mem_oe_n));

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  assert_window_bound_R7: assert property (@(posedge clk) disable iff (rst)
    open_cnt <= WPT_CYC + 3);

  assert_backup_needs_arm_R10: assert property (@(posedge clk) disable iff (rst)
    sel_backup |-> bkup_armed);

  assert_arm_sticky_R11: assert property (@(posedge clk) disable iff (arm_clear)
    bkup_armed |=> bkup_armed);
endmodule

bind pwrfail_guard pwrfail_guard_chk #(.WPT_CYC(WPT_CYC)) u_chk (
  .clk(clk), .rst(rst), .arm_clear(arm_clear), .vdd_low(vdd_low),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .bus_drive(bus_drive), .sel_backup(sel_backup),
  .prot_active(prot_active), .bkup_armed(bkup_armed)
);

// File: tb/pwrfail_guard_tb.sv
`timescale 1ns/1ps
module pwrfail_guard_tb;
  localparam int WPT = 8;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst, arm_clear, ce_n, we_n, oe_n, vlow, blow;
  logic mce_n, mwe_n, moe_n, drv, sel, prot, armed;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  pwrfail_guard #(.WPT_CYC(WPT), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst(rst), .arm_clear(arm_clear),
    .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
    .vdd_low(vlow), .vdd_bkup_low(blow),
    .mem_ce_n(mce_n), .mem_we_n(mwe_n), .mem_oe_n(moe_n),
    .bus_drive(drv), .sel_backup(sel), .prot_active(prot), .bkup_armed(armed)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    rst = 1; arm_clear = 1; ce_n = 1; we_n = 1; oe_n = 1; vlow = 1; blow = 1;
    tick(4);
    chk("R1 prot", prot, 1'b1);
    chk("R1 mem_ce_n", mce_n, 1'b1);
    chk("R1 mem_we_n", mwe_n, 1'b1);
    chk("R1 mem_oe_n", moe_n, 1'b1);
    chk("R1 drive", drv, 1'b0);
    chk("R1 sel", sel, 1'b0);
    arm_clear = 0; tick(1);
    rst = 0; tick(6);
    chk("R9 armed before supply", armed, 1'b0);
    chk("R9 sel before supply", sel, 1'b0);
    chk("R1 prot after release", prot, 1'b1);
  endtask

  task automatic t_power_up;
    vlow = 0; blow = 0;
    tick(2); chk("R10 armed latency", armed, 1'b0);
    tick(1); chk("R10 armed set", armed, 1'b1);
    ce_n = 0; we_n = 0;
    tick(5);
    chk("R8 write blocked in recovery", mwe_n, 1'b1);
    chk("R8 ce blocked in recovery", mce_n, 1'b1);
    ce_n = 1; we_n = 1;
    tick(14); chk("R8 still protected", prot, 1'b1);
    tick(1);  chk("R8 protection released", prot, 1'b0);
  endtask

  task automatic t_modes;
    ce_n = 1; tick(3);
    chk("R2 standby ce", mce_n, 1'b1);
    chk("R2 standby drive", drv, 1'b0);
    ce_n = 0; we_n = 1; oe_n = 1; tick(3);
    chk("R2 outoff ce", mce_n, 1'b0);
    chk("R2 outoff drive", drv, 1'b0);
    oe_n = 0;
    tick(2); chk("R2 read latency", drv, 1'b0);
    tick(1); chk("R2 read drive", drv, 1'b1);
    chk("R2 read oe", moe_n, 1'b0);
    we_n = 0; tick(3);
    chk("R2 write drive", drv, 1'b0);
    chk("R2 write we", mwe_n, 1'b0);
    we_n = 1; tick(3);
    chk("R4 ce-first read resumes", drv, 1'b1);
    ce_n = 1; oe_n = 1; tick(3);
  endtask

  task automatic t_write_overlap;
    we_n = 0; tick(3);
    chk("R3 we alone", mwe_n, 1'b1);
    ce_n = 0;
    tick(2); chk("R3 start latency", mwe_n, 1'b1);
    tick(1); chk("R3 start at later fall", mwe_n, 1'b0);
    ce_n = 1; tick(3);
    chk("R3 end at ce rise", mwe_n, 1'b1);
    we_n = 1; ce_n = 0; tick(3);
    we_n = 0; tick(3);
    chk("R3 we-led start", mwe_n, 1'b0);
    we_n = 1; tick(3);
    chk("R3 end at we rise", mwe_n, 1'b1);
    ce_n = 1; tick(3);
  endtask

  task automatic t_write_first;
    oe_n = 0; we_n = 0; tick(3);
    ce_n = 0; tick(3);
    chk("R4 ce after we drive", drv, 1'b0);
    we_n = 1; tick(3);
    chk("R4 stays undriven", drv, 1'b0);
    ce_n = 1; tick(3);
    ce_n = 0; tick(3);
    chk("R4 new cycle drives", drv, 1'b1);
    ce_n = 1; tick(3);
    ce_n = 0; we_n = 0; tick(3);
    we_n = 1; tick(3);
    chk("R4 simultaneous fall", drv, 1'b0);
    ce_n = 1; oe_n = 1; tick(3);
  endtask

  task automatic t_fail_idle;
    vlow = 1;
    tick(2); chk("R5 prot latency", prot, 1'b0);
    tick(1); chk("R5 prot set", prot, 1'b1);
    ce_n = 0; we_n = 0; tick(4);
    chk("R5 write ignored", mwe_n, 1'b1);
    chk("R5 ce ignored", mce_n, 1'b1);
    we_n = 1; oe_n = 0; tick(4);
    chk("R5 read ignored", drv, 1'b0);
    ce_n = 1; oe_n = 1; vlow = 0; tick(REC + 5);
    chk("R8 back to normal", prot, 1'b0);
  endtask

  task automatic t_fail_drain_end;
    ce_n = 0; we_n = 0; tick(4);
    vlow = 1; tick(5);
    chk("R6 write continues", mwe_n, 1'b0);
    chk("R6 not yet protected", prot, 1'b0);
    we_n = 1;
    tick(2); chk("R6 end latency", prot, 1'b0);
    tick(1); chk("R6 protected after end", prot, 1'b1);
    ce_n = 1; vlow = 0; tick(REC + 5);
  endtask

  task automatic t_fail_drain_timeout;
    ce_n = 0; we_n = 0; tick(4);
    vlow = 1; tick(10);
    chk("R7 write before timeout", mwe_n, 1'b0);
    chk("R7 prot before timeout", prot, 1'b0);
    tick(1);
    chk("R7 prot at timeout", prot, 1'b1);
    chk("R7 write cut", mwe_n, 1'b1);
    ce_n = 1; we_n = 1; vlow = 0; tick(REC + 5);
  endtask

  task automatic t_backup;
    vlow = 1; tick(3);
    blow = 1; tick(3);
    chk("R10 backup selected", sel, 1'b1);
    blow = 0; tick(3);
    chk("R10 main reselected", sel, 1'b0);
    vlow = 0; tick(REC + 5);
    rst = 1; tick(2);
    chk("R11 armed survives reset", armed, 1'b1);
    rst = 0; tick(REC + 6);
    chk("R11 armed after reset", armed, 1'b1);
    arm_clear = 1; tick(1);
    chk("R11 clear", armed, 1'b0);
    vlow = 1; tick(3); blow = 1; tick(4);
    chk("R9 no backup while disarmed", sel, 1'b0);
    arm_clear = 0; tick(4);
    chk("R9 still disarmed", armed, 1'b0);
    blow = 0; tick(1); vlow = 0; tick(4);
    chk("R10 rearmed", armed, 1'b1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_modes();
    t_write_overlap();
    t_write_first();
    t_fail_idle();
    t_fail_drain_end();
    t_fail_drain_timeout();
    t_backup();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule